// File: doc/BRIEF.md
# Pseudo-SRAM Deep Power-Down and Standby Sequencer

This block tracks the power state of a pseudo-SRAM die. It watches the active-low chip enable, a deep-power-down request bit that software sets through the refresh configuration register, and a one-cycle microsecond tick. From these it decides whether the array is being accessed, idling in standby, sitting in deep power-down with refresh stopped, or running the reinitialization that follows a wake-up. It drives refresh enable, a ready flag for the access path, and a flag that warns the contents were lost.

Deep power-down takes two steps. First a configuration write arms the request. Entry then happens only on the next chip-enable rising edge. Wake-up requires chip enable to be held low for a qualification window of `QUAL_US` ticks, then a reinitialization of `INIT_US` ticks. Only after both does the access path see ready again. Configuration writes take effect only in standby, and the request bit clears itself when the device wakes.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset, state is STANDBY (code 1), `refresh_en` and `ready` are 1, and `data_lost` and `dpd_armed` are 0.
- R2: When the request is not armed, the state is ACTIVE (code 0) on the clock edge that samples `ce_n` low and STANDBY (code 1) on the edge that samples it high.
- R3: `cfg_accept` is 1 only when `cfg_wr` is 1, the state is STANDBY and `ce_n` is high. An accepted write loads `cfg_dpd` into `dpd_armed` at the next edge. A write in any other condition leaves `dpd_armed` unchanged.
- R4: With `dpd_armed` set, the edge that samples `ce_n` high while in ACTIVE moves the state to DEEP_PD (code 2), and `refresh_en` and `ready` drop to 0.
- R5: In DEEP_PD, the state moves to INIT (code 3) on the edge that samples the `QUAL_US`-th `us_tick` of an unbroken run of `ce_n` low. Any cycle with `ce_n` high restarts the count, and ticks taken with `ce_n` high do not count.
- R6: INIT ignores `ce_n` until the edge that samples the `INIT_US`-th tick. On that edge the state becomes ACTIVE if `ce_n` is low and STANDBY if it is high, and `ready` is 1 from the following cycle on. `ready` stays 0 for the whole of DEEP_PD and INIT.
- R7: `dpd_armed` clears on the edge that leaves DEEP_PD. A later chip-enable rising edge from ACTIVE then goes to STANDBY.
- R8: `data_lost` is set on entry to DEEP_PD. It clears on the edge that samples `wr_acc` high while `ready` is 1, and `wr_acc` has no effect while `ready` is 0.
- R9: `refresh_en` is 0 only in DEEP_PD. It is 1 in INIT, ACTIVE and STANDBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| cfg_wr | input | 1 | Refresh configuration register write strobe |
| cfg_dpd | input | 1 | Deep-power-down request value carried by the write |
| wr_acc | input | 1 | Write access strobe from the access path |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| refresh_en | output | 1 | Array refresh enable |
| ready | output | 1 | Access path may issue reads and writes |
| data_lost | output | 1 | Contents were lost in deep power-down |
| dpd_armed | output | 1 | Deep-power-down request bit as stored |
| cfg_accept | output | 1 | The current configuration write is accepted |
| state | output | 2 | 0 ACTIVE, 1 STANDBY, 2 DEEP_PD, 3 INIT |

## Verification
The bench sweeps every point at which the wake-up qualification can be broken by chip enable going high. A design that failed to restart its counter would wake early after a short glitch. It counts tick by tick through both windows and checks that the transition lands on exactly the final tick; an off-by-one counter shows up as a state change one tick early or late. It issues configuration writes in ACTIVE and DEEP_PD, which a loosely gated design would accept. It takes a second chip-enable rise after wake-up, which re-enters deep power-down if the request bit is not cleared on exit. It also sends a write access during INIT, which a careless design would let clear the data-lost flag before ready.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_DPD     = 2'd2,
    PS_INIT    = 2'd3
  } pwr_state_e;

  // bits to hold a count running 0 .. limit-1
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // access path may run
  function automatic logic may_access(input pwr_state_e s);
    return (s == PS_ACTIVE) || (s == PS_STANDBY);
  endfunction

  // refresh is stopped only while powered down
  function automatic logic keeps_refresh(input pwr_state_e s);
    return s != PS_DPD;
  endfunction

  // resting state chosen from chip enable
  function automatic pwr_state_e settle(input logic ce_n);
    return ce_n ? PS_STANDBY : PS_ACTIVE;
  endfunction

endpackage

// File: rtl/pwr_tick_cnt.sv
module pwr_tick_cnt #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit
);
  import psram_pwr_pkg::*;

  localparam int W = cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = tick && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + 1'b1;
  end

  // R5/R6: the window count never passes its final value
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: a clear always empties the count
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_cfg_gate.sv
module pwr_cfg_gate
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state_i,
  input  logic       ce_n,
  input  logic       cfg_wr,
  input  logic       cfg_dpd,
  input  logic       exit_i,
  output logic       accept_o,
  output logic       armed_o
);

  logic armed_q;

  assign accept_o = cfg_wr && ce_n && (state_i == PS_STANDBY);
  assign armed_o  = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (exit_i)   armed_q <= 1'b0;
    else if (accept_o) armed_q <= cfg_dpd;
  end

  // R3: the request bit changes only through a standby write or a wake-up
  p_cfg_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q != $past(armed_q)) && !$past(exit_i)
      |-> $past(state_i == PS_STANDBY) && $past(ce_n) && $past(cfg_wr));

  // R7: leaving deep power-down drops the request
  p_armed_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i |=> !armed_q);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       armed_i,
  input  logic       qual_hit_i,
  input  logic       init_hit_i,
  input  logic       wr_acc,
  output pwr_state_e state_o,
  output logic       enter_dpd_o,
  output logic       exit_dpd_o,
  output logic       data_lost_o
);

  pwr_state_e state_q, state_d;
  logic       lost_q;
  logic       lost_clr;

  assign enter_dpd_o = (state_q == PS_ACTIVE) && ce_n && armed_i;
  assign exit_dpd_o  = (state_q == PS_DPD) && qual_hit_i;
  assign lost_clr    = wr_acc && may_access(state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACTIVE:  state_d = enter_dpd_o ? PS_DPD : settle(ce_n);
      PS_STANDBY: state_d = settle(ce_n);
      PS_DPD:     if (qual_hit_i) state_d = PS_INIT;
      PS_INIT:    if (init_hit_i) state_d = settle(ce_n);
      default:    state_d = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_STANDBY;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter_dpd_o)   lost_q <= 1'b1;
      else if (lost_clr) lost_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign data_lost_o = lost_q;

  // R4: power-down is entered only from ACTIVE on chip enable high with the request set
  p_dpd_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DPD) && ($past(state_q) != PS_DPD)
      |-> ($past(state_q) == PS_ACTIVE) && $past(ce_n) && $past(armed_i));

  // R5: wake-up needs a qualifying tick with chip enable low
  p_dpd_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_INIT) && ($past(state_q) == PS_DPD)
      |-> $past(!ce_n) && $past(qual_hit_i));

  // R6: initialization ends only when its window expires
  p_init_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_INIT) && ($past(state_q) == PS_INIT) |-> $past(init_hit_i));

  // R8: entry raises the data-lost flag
  p_lost_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dpd_o |=> lost_q);

  // R8: the flag never falls while accesses are blocked
  p_lost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> may_access($past(state_q)) && $past(wr_acc));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int QUAL_US = 10,
  parameter int INIT_US = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cfg_wr,
  input  logic       cfg_dpd,
  input  logic       wr_acc,
  input  logic       us_tick,
  output logic       refresh_en,
  output logic       ready,
  output logic       data_lost,
  output logic       dpd_armed,
  output logic       cfg_accept,
  output logic [1:0] state
);

  pwr_state_e cur_state;
  logic       armed;
  logic       qual_clr, init_clr;
  logic       qual_hit, init_hit;
  logic       enter_dpd, exit_dpd;

  // wake-up window runs only in power-down with chip enable held low
  assign qual_clr = !((cur_state == PS_DPD) && !ce_n);
  assign init_clr = (cur_state != PS_INIT);

  pwr_tick_cnt #(.LIMIT(QUAL_US)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(qual_clr), .tick(us_tick), .hit(qual_hit)
  );

  pwr_tick_cnt #(.LIMIT(INIT_US)) u_init (
    .clk(clk), .rst_n(rst_n), .clr(init_clr), .tick(us_tick), .hit(init_hit)
  );

  pwr_cfg_gate u_cfg (
    .clk(clk), .rst_n(rst_n), .state_i(cur_state), .ce_n(ce_n),
    .cfg_wr(cfg_wr), .cfg_dpd(cfg_dpd), .exit_i(exit_dpd),
    .accept_o(cfg_accept), .armed_o(armed)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .armed_i(armed),
    .qual_hit_i(qual_hit), .init_hit_i(init_hit), .wr_acc(wr_acc),
    .state_o(cur_state), .enter_dpd_o(enter_dpd), .exit_dpd_o(exit_dpd),
    .data_lost_o(data_lost)
  );

  assign refresh_en = keeps_refresh(cur_state);
  assign ready      = may_access(cur_state);
  assign dpd_armed  = armed;
  assign state      = cur_state;

  // R9: refresh is stopped exactly when the sequencer entered power-down
  p_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refresh_en) |-> $past(enter_dpd));

  // R6: ready returns only at the end of initialization
  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(init_hit));

endmodule

// File: tb/tb_psram_pwr_seq.sv
module tb_psram_pwr_seq;

  localparam int QUAL = 3;
  localparam int INIT = 5;

  logic clk = 1'b0;
  logic rst_n, ce_n, cfg_wr, cfg_dpd, wr_acc, us_tick;
  logic refresh_en, ready, data_lost, dpd_armed, cfg_accept;
  logic [1:0] state;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  psram_pwr_seq #(.QUAL_US(QUAL), .INIT_US(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cfg_wr(cfg_wr), .cfg_dpd(cfg_dpd),
    .wr_acc(wr_acc), .us_tick(us_tick), .refresh_en(refresh_en), .ready(ready),
    .data_lost(data_lost), .dpd_armed(dpd_armed), .cfg_accept(cfg_accept),
    .state(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // one-cycle tick; the state is sampled after the edge that saw it
  task automatic tick();
    us_tick = 1'b1;
    cyc();
    us_tick = 1'b0;
  endtask

  task automatic arm();
    cfg_wr = 1'b1; cfg_dpd = 1'b1;
    cyc();
    cfg_wr = 1'b0; cfg_dpd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; cfg_wr = 0; cfg_dpd = 0; wr_acc = 0; us_tick = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 state", state, 1);
    chk("R1 refresh_en", refresh_en, 1);
    chk("R1 ready", ready, 1);
    chk("R1 data_lost", data_lost, 0);
    chk("R1 dpd_armed", dpd_armed, 0);

    // R2 state follows chip enable
    ce_n = 0; cyc(); chk("R2 active", state, 0);
    ce_n = 1; cyc(); chk("R2 standby", state, 1);

    // R3 write during ACTIVE is refused
    ce_n = 0; cyc();
    cfg_wr = 1; cfg_dpd = 1; #1;
    chk("R3 accept in active", cfg_accept, 0);
    cyc(); cfg_wr = 0; cfg_dpd = 0;
    chk("R3 armed after refused write", dpd_armed, 0);
    ce_n = 1; cyc();
    chk("R7 unarmed rise goes standby", state, 1);
    // R3 write in standby is accepted, then overwritten
    cfg_wr = 1; cfg_dpd = 1; #1;
    chk("R3 accept in standby", cfg_accept, 1);
    cyc(); cfg_wr = 0;
    chk("R3 armed set", dpd_armed, 1);
    cfg_wr = 1; cfg_dpd = 0; cyc(); cfg_wr = 0;
    chk("R3 armed rewritten", dpd_armed, 0);
    arm();
    chk("R3 armed again", dpd_armed, 1);

    // R4 entry on next rise
    ce_n = 0; cyc(); chk("R4 active while armed", state, 0);
    ce_n = 1; cyc();
    chk("R4 state dpd", state, 2);
    chk("R4 ready", ready, 0);
    chk("R9 refresh off in dpd", refresh_en, 0);
    chk("R8 lost set", data_lost, 1);
    cfg_wr = 1; cfg_dpd = 0; #1;
    chk("R3 accept in dpd", cfg_accept, 0);
    cyc(); cfg_wr = 0;
    chk("R3 armed kept in dpd", dpd_armed, 1);

    // R5 ticks with ce high do not count
    for (int i = 0; i < QUAL + 2; i++) begin tick(); cyc(); end
    chk("R5 ticks with ce high", state, 2);
    // R5 every abort point restarts qualification
    for (int j = 1; j < QUAL; j++) begin
      ce_n = 0;
      for (int k = 0; k < j; k++) begin tick(); cyc(); end
      ce_n = 1; cyc();
      chk("R5 abort keeps dpd", state, 2);
    end
    ce_n = 0;
    for (int k = 0; k < QUAL - 1; k++) begin tick(); cyc(); end
    chk("R5 one tick short", state, 2);
    tick();
    chk("R5 enters init", state, 3);
    chk("R6 ready low in init", ready, 0);
    chk("R9 refresh on in init", refresh_en, 1);
    chk("R7 armed cleared", dpd_armed, 0);

    // R6 ce ignored in init; R8 write while not ready ignored
    ce_n = 1; cyc(); chk("R6 ce ignored in init", state, 3);
    ce_n = 0; wr_acc = 1; cyc(); wr_acc = 0;
    chk("R8 write during init ignored", data_lost, 1);
    for (int k = 0; k < INIT - 1; k++) begin
      tick(); cyc();
      chk("R6 still init", state, 3);
    end
    tick();
    chk("R6 exit to active", state, 0);
    chk("R6 ready", ready, 1);

    // R7 no re-entry on next rise
    ce_n = 1; cyc();
    chk("R7 rise after wake goes standby", state, 1);
    chk("R8 lost still set", data_lost, 1);
    wr_acc = 1; cyc(); wr_acc = 0;
    chk("R8 lost cleared", data_lost, 0);

    // second round: wake with ce high at the end of init
    arm();
    ce_n = 0; cyc(); ce_n = 1; cyc();
    chk("R4 second entry", state, 2);
    ce_n = 0;
    for (int k = 0; k < QUAL; k++) tick();
    chk("R5 back-to-back ticks wake", state, 3);
    ce_n = 1;
    for (int k = 0; k < INIT; k++) tick();
    chk("R6 exit to standby", state, 1);
    chk("R6 ready after standby exit", ready, 1);
    chk("R9 refresh in standby", refresh_en, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule